// File: doc/BRIEF.md
# Scrolled LCD Row Address Mapper

This block converts the line index from a frame scan counter into the number of the physical row driver that should be energised for that line on a matrix LCD. It supports vertical scrolling by a programmable offset and four multiplex rates. Optionally the last line of the frame is a fixed icon row. That row never scrolls and always lands on a dedicated driver that depends on the multiplex rate.

Each cycle the block takes the multiplex rate select, the icon-mode bit, the scroll offset and the scan line. One clock later it presents the driver number, a flag that marks the icon row, and an error flag for an offset outside the legal range. The modulo wrap uses a single conditional subtraction, so no divider is needed. Vertical mirroring is not modelled; the driver numbers below assume mirroring is off.

Top module: `lcd_row_mapper`

## Requirements
- R1: The rate select `mux_sel` encodes the number of lines M per frame: 2'b00 gives 33, 2'b01 gives 49, 2'b10 gives 65 and 2'b11 gives 81.
- R2: With `icon_mode` = 0, all M lines scroll. Scan line i (i < M) maps to row (i + offset) mod M, and `icon_row` is 0.
- R3: With `icon_mode` = 1, the graphic lines are i < M-1. Each maps to row (i + offset) mod (M-1), and `icon_row` is 0.
- R4: With `icon_mode` = 1, scan line M-1 is the icon row. It maps to driver 56, 64, 72 or 80 for M = 33, 49, 65 or 81, with `icon_row` = 1, whatever the offset.
- R5: The legal offset range is 0..M-2 in icon mode and 0..M-1 otherwise. A larger offset sets `ofs_err` to 1, and the mapping then behaves as if the offset were 0. A legal offset gives `ofs_err` = 0.
- R6: A scan line of M or more gives row 0 with `icon_row` = 0.
- R7: The outputs are registered. A result appears on the first rising edge after the inputs are applied.
- R8: A synchronous active-high `rst` clears the row to 0 and both flags to 0 on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mux_sel | input | 2 | Multiplex rate select |
| icon_mode | input | 1 | 1 = last line is a non-scrolling icon row |
| scroll_ofs | input | 7 | Vertical scroll offset |
| scan_line | input | 7 | Current scan line index |
| row_drv | output | 7 | Physical row driver number |
| icon_row | output | 1 | Current line is the icon row |
| ofs_err | output | 1 | Offset out of range for the current mode |

## Verification
The sweep covers every rate and both icon modes, with every offset up to one past the legal maximum plus the largest offset, against every scan line up to one past the frame.

The wrap point is the main target. A design that wraps at M instead of M-1 in icon mode sends the last graphic line to a row equal to M-1 instead of back toward zero. A design with an off-by-one range check either flags the largest legal offset or lets offset M-1 through in icon mode.

Icon lines are checked for a driver that stays fixed as the offset moves. Scan lines beyond the frame are checked to land on row 0, which catches a design that lets them feed the adder.

// File: rtl/lcd_row_map_pkg.sv
package lcd_row_map_pkg;

    localparam int ROW_W = 7;
    localparam int SUM_W = ROW_W + 1;

    typedef enum logic [1:0] {
        MUX33 = 2'b00,
        MUX49 = 2'b01,
        MUX65 = 2'b10,
        MUX81 = 2'b11
    } mux_rate_e;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic             icon;
        logic             err;
    } row_map_t;

    // Lines per frame for a given rate
    function automatic logic [ROW_W-1:0] mux_lines(input mux_rate_e m);
        case (m)
            MUX33:   return ROW_W'(33);
            MUX49:   return ROW_W'(49);
            MUX65:   return ROW_W'(65);
            default: return ROW_W'(81);
        endcase
    endfunction

    // Fixed driver used by the icon line, mirroring off
    function automatic logic [ROW_W-1:0] icon_driver(input mux_rate_e m);
        case (m)
            MUX33:   return ROW_W'(56);
            MUX49:   return ROW_W'(64);
            MUX65:   return ROW_W'(72);
            default: return ROW_W'(80);
        endcase
    endfunction

endpackage

// File: rtl/lcd_ofs_check.sv
module lcd_ofs_check
    import lcd_row_map_pkg::*;
#(
    parameter int W = ROW_W
) (
    input  logic [W-1:0] lines,
    input  logic         icon_mode,
    input  logic [W-1:0] ofs,
    output logic [W-1:0] span,
    output logic [W-1:0] ofs_eff,
    output logic         err
);
    // Number of lines that take part in scrolling
    always_comb begin
        span    = icon_mode ? (lines - W'(1)) : lines;
        err     = (ofs >= span);
        ofs_eff = err ? '0 : ofs;
    end
endmodule

// File: rtl/lcd_row_wrap.sv
module lcd_row_wrap
    import lcd_row_map_pkg::*;
#(
    parameter int W = ROW_W
) (
    input  logic [W-1:0] line_idx,
    input  logic [W-1:0] ofs_eff,
    input  logic [W-1:0] span,
    output logic [W-1:0] row
);
    localparam int SW = W + 1;
    logic [SW-1:0] sum;
    logic [SW-1:0] diff;

    // Both operands are below span, so one subtraction is enough
    always_comb begin
        sum  = SW'(line_idx) + SW'(ofs_eff);
        diff = sum - SW'(span);
        row  = (sum >= SW'(span)) ? diff[W-1:0] : sum[W-1:0];
    end

    always_comb begin
        if (line_idx < span && ofs_eff < span)
            p_wrap_bound_r2: assert (row < span);
    end
endmodule

// File: rtl/lcd_row_mapper.sv
module lcd_row_mapper
    import lcd_row_map_pkg::*;
#(
    parameter int W = ROW_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   mux_sel,
    input  logic         icon_mode,
    input  logic [W-1:0] scroll_ofs,
    input  logic [W-1:0] scan_line,
    output logic [W-1:0] row_drv,
    output logic         icon_row,
    output logic         ofs_err
);
    mux_rate_e    rate;
    logic [W-1:0] lines;
    logic [W-1:0] span;
    logic [W-1:0] ofs_eff;
    logic         err_c;
    logic [W-1:0] wrapped;
    logic         is_icon;
    logic         beyond;
    row_map_t     nxt;
    row_map_t     cur;

    always_comb begin
        rate  = mux_rate_e'(mux_sel);
        lines = W'(mux_lines(rate));
    end

    lcd_ofs_check #(.W(W)) u_chk (
        .lines     (lines),
        .icon_mode (icon_mode),
        .ofs       (scroll_ofs),
        .span      (span),
        .ofs_eff   (ofs_eff),
        .err       (err_c)
    );

    lcd_row_wrap #(.W(W)) u_wrap (
        .line_idx (scan_line),
        .ofs_eff  (ofs_eff),
        .span     (span),
        .row      (wrapped)
    );

    always_comb begin
        beyond  = (scan_line >= lines);
        is_icon = icon_mode && (scan_line == lines - W'(1));
        nxt.err = err_c;
        if (beyond) begin
            nxt.row  = '0;
            nxt.icon = 1'b0;
        end else if (is_icon) begin
            nxt.row  = W'(icon_driver(rate));
            nxt.icon = 1'b1;
        end else begin
            nxt.row  = wrapped;
            nxt.icon = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign row_drv  = cur.row;
    assign icon_row = cur.icon;
    assign ofs_err  = cur.err;

    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> (row_drv == '0 && !icon_row && !ofs_err));

    p_icon_fixed_r4: assert property (@(posedge clk) disable iff (rst)
        (icon_row && !$past(rst)) |->
            (row_drv == W'(56) + W'(8) * W'($past(mux_sel))));

    p_icon_only_mode_r4: assert property (@(posedge clk) disable iff (rst)
        (icon_row && !$past(rst)) |-> $past(icon_mode));

    p_beyond_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(beyond)) |-> (row_drv == '0 && !icon_row));

    p_err_as_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ofs_err && !icon_row && $past(scan_line) == '0)
            |-> (row_drv == '0));

    p_graphic_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !icon_row) |-> (row_drv < $past(span) || row_drv == '0));
endmodule

// File: tb/lcd_row_mapper_test.sv
module lcd_row_mapper_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mux_sel = 2'b00;
    logic       icon_mode = 1'b0;
    logic [6:0] scroll_ofs = '0;
    logic [6:0] scan_line = '0;
    logic [6:0] row_drv;
    logic       icon_row;
    logic       ofs_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    lcd_row_mapper uut (
        .clk(clk), .rst(rst), .mux_sel(mux_sel), .icon_mode(icon_mode),
        .scroll_ofs(scroll_ofs), .scan_line(scan_line),
        .row_drv(row_drv), .icon_row(icon_row), .ofs_err(ofs_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s sel=%0d icon=%0d ofs=%0d line=%0d: actual %0d expected %0d",
                     req, mux_sel, icon_mode, scroll_ofs, scan_line, act, exp);
        end
    endtask

    initial begin
        #1500000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int m, span, maxo, er, eo, erow, eicon;
        string tag;
        repeat (2) @(negedge clk);
        // R8: reset state
        check("R8 row", row_drv, 0);
        check("R8 icon", icon_row, 0);
        check("R8 err", ofs_err, 0);
        rst = 1'b0;
        for (int s = 0; s < 4; s++) begin
            for (int im = 0; im < 2; im++) begin
                m    = 33 + 16 * s;          // R1 line count
                span = im ? m - 1 : m;
                for (int o = 0; o <= span + 1; o++) begin
                    for (int ln = 0; ln <= m; ln++) begin
                        mux_sel = 2'(s); icon_mode = im[0];
                        scroll_ofs = (o == span + 1) ? 7'd127 : 7'(o);
                        scan_line = 7'(ln);
                        er = (int'(scroll_ofs) >= span) ? 1 : 0;
                        eo = er ? 0 : int'(scroll_ofs);
                        if (ln >= m) begin
                            erow = 0; eicon = 0; tag = "R6";
                        end else if (im == 1 && ln == m - 1) begin
                            erow = 56 + 8 * s; eicon = 1; tag = "R4";
                        end else begin
                            erow = (ln + eo) % span; eicon = 0;
                            tag = im ? "R3" : "R2";
                        end
                        @(negedge clk);   // R7: one edge later
                        check({tag, " R1 R7 row"}, row_drv, erow);
                        check({tag, " icon"}, icon_row, eicon);
                        check("R5 err", ofs_err, er);
                    end
                end
            end
        end
        // R8: reset mid-run with an active icon result
        mux_sel = 2'b11; icon_mode = 1'b1; scroll_ofs = 7'd127; scan_line = 7'd80;
        @(negedge clk);
        check("R4 pre-reset", row_drv, 80);
        rst = 1'b1;
        @(negedge clk);
        check("R8 row", row_drv, 0);
        check("R8 icon", icon_row, 0);
        check("R8 err", ofs_err, 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule